// File: doc/BRIEF.md
# CPU Clock Select and Power-Down Controller

This block produces the processor clock and controls the power-down modes. The clock comes from one of two sources. The first is the main oscillator divided by 4, 8 or 64. The second is the 32.768 kHz subsystem oscillator divided by 4, which gives an instruction cycle of about 122 µs. A new source or ratio takes effect only at a rising edge of the processor clock, so the output never carries a shortened phase.

Software writes a small register bank through a write-only bus. Idle mode holds the processor clock low while the main oscillator keeps running. Stop mode also turns off the main oscillator enable. Any enabled interrupt request ends idle mode at once. When an interrupt ends stop mode, a stabilization wait runs first, and its length comes from a programmable code. Every reset also starts a fixed stabilization wait of 2^17 main-clock periods. During either wait the processor clock stays low.

The analog oscillators sit outside the block. The main oscillator is the block clock `clk`, and `main_osc_en` models its enable. The subsystem oscillator arrives on `sub_clk` and is synchronized inside the block, and `sub_osc_en` models its enable.

Top module: `cpuclk_pwr_ctrl`

## Requirements
- R1: After reset, the source field resets to the main clock divided by 64, and both oscillator enables are 1. The processor clock stays low for at least 2^RST_WAIT_LOG2 clock cycles (default 17) and then starts with a period of 64 cycles.
- R2: Writing address 0 sets the source field in bits [1:0]. The value 00 selects a 64-cycle period, 01 selects 8 cycles and 10 selects 4 cycles.
- R3: The source value 11 selects the subsystem clock. The processor clock period is then 4 subsystem periods.
- R4: After a source or ratio change, every high phase and every low phase of the processor clock lasts at least 2 clock cycles. The change takes effect at the next rising edge.
- R5: Writing address 2 with bit 0 set and bit 1 clear enters idle mode. The processor clock settles low and stays low, and `main_osc_en` stays 1.
- R6: A high `irq` in idle mode restarts the processor clock. The first rising edge comes within 6 cycles at the divide-by-4 ratio, and no stabilization wait is applied.
- R7: Writing address 2 with bit 1 set enters stop mode. The processor clock settles low, `main_osc_en` drops to 0, and both stay that way until `irq`.
- R8: A high `irq` in stop mode sets `main_osc_en` again. The processor clock then stays low for at least 2^(IRQ_WAIT_BASE + 2*code) cycles, where the code is bits [1:0] last written to address 1, and then resumes.
- R9: Bit 2 of address 0 set to 1 drops `sub_osc_en` while the main oscillator is the source. The bit is ignored, and `sub_osc_en` stays 1, while the subsystem source is selected or still in use.
- R10: A command write at address 2 with both bits 0 and 1 set enters stop mode, not idle mode.
- R11: `irq` while the processor clock is running has no effect on its period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock, also the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 mode, 1 wake-wait code, 2 power command |
| wr_data | input | 3 | Register write data |
| irq | input | 1 | OR of the enabled interrupt requests |
| sub_clk | input | 1 | Subsystem oscillator clock, asynchronous |
| cpu_clk | output | 1 | Processor clock |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Subsystem oscillator enable |

## Verification
A wrong phase counter or a stale latched source shows up at `cpu_clk` within one period, as a wrong period length or as a phase shorter than two cycles. A wrong power state shows up at once on `main_osc_en`, or as a clock that keeps toggling through idle. A wrong wait count shows up only when the wait expires, as a first rising edge outside its window. The bench therefore times the cycles from each release event to the first edge, and it watches every phase width for the whole run.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {
    SRC_DIV64 = 2'b00,
    SRC_DIV8  = 2'b01,
    SRC_DIV4  = 2'b10,
    SRC_SUB   = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    PS_WAIT,
    PS_RUN,
    PS_IDLE,
    PS_STOP
  } pwr_state_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_WAKE = 2'd1;
  localparam logic [1:0] ADDR_CMD  = 2'd2;
endpackage

// File: rtl/cpc_edge_sync.sv
module cpc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [2:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b000;
    else        sync_q <= {sync_q[1:0], async_in};
  end

  assign rise = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/cpc_clk_gen.sv
module cpc_clk_gen
  import cpc_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 64,
  parameter int SUB_DIV  = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  clk_src_e sel_req,
  input  logic     sub_tick,
  output logic     cpu_clk,
  output clk_src_e sel_cur
);
  localparam int CW = $clog2(DIV_SLOW / 2 + 1);

  logic [CW-1:0] cnt_q, cnt_d, half_len;
  logic          clk_d, tick, last;
  clk_src_e      sel_d;

  always_comb begin
    case (sel_cur)
      SRC_DIV4: half_len = CW'(DIV_FAST / 2);
      SRC_DIV8: half_len = CW'(DIV_MID / 2);
      SRC_SUB:  half_len = CW'(SUB_DIV / 2);
      default:  half_len = CW'(DIV_SLOW / 2);
    endcase
    tick = (sel_cur == SRC_SUB) ? sub_tick : 1'b1;
    last = (cnt_q == half_len - 1'b1);
  end

  // A high phase always runs to completion; a low phase is frozen while
  // halted and the new source is adopted only when a rising edge is issued.
  always_comb begin
    clk_d = cpu_clk;
    cnt_d = cnt_q;
    sel_d = sel_cur;
    if (cpu_clk) begin
      if (tick) begin
        if (last) begin
          clk_d = 1'b0;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      if (last) begin
        clk_d = 1'b1;
        cnt_d = '0;
        sel_d = sel_req;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_clk <= 1'b0;
      cnt_q   <= '0;
      sel_cur <= SRC_DIV64;
    end else begin
      cpu_clk <= clk_d;
      cnt_q   <= cnt_d;
      sel_cur <= sel_d;
    end
  end
endmodule

// File: rtl/cpc_pwr_fsm.sv
module cpc_pwr_fsm
  import cpc_pkg::*;
#(
  parameter int RST_WAIT_LOG2 = 17,
  parameter int IRQ_WAIT_BASE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_idle,
  input  logic       cmd_stop,
  input  logic       irq,
  input  logic [1:0] wake_code,
  input  logic       cpu_low,
  output logic       run,
  output logic       idle,
  output logic       main_osc_en
);
  localparam int IRQ_MAX_LOG2 = IRQ_WAIT_BASE + 6;
  localparam int WW = ((RST_WAIT_LOG2 > IRQ_MAX_LOG2) ? RST_WAIT_LOG2 : IRQ_MAX_LOG2) + 1;
  localparam logic [WW-1:0] RST_LOAD = WW'((64'd1 << RST_WAIT_LOG2) - 64'd1);

  pwr_state_e    state_q, state_d;
  logic [WW-1:0] wcnt_q, wcnt_d, irq_load;
  logic [7:0]    shamt;

  always_comb begin
    shamt    = 8'(IRQ_WAIT_BASE) + {5'b0, wake_code, 1'b0};
    irq_load = (WW'(1) << shamt) - WW'(1);
  end

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    case (state_q)
      PS_WAIT: begin
        if (wcnt_q == '0) state_d = PS_RUN;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      PS_RUN: begin
        if (cmd_stop)      state_d = PS_STOP;
        else if (cmd_idle) state_d = PS_IDLE;
      end
      PS_IDLE: begin
        if (irq) state_d = PS_RUN;
      end
      default: begin
        if (irq) begin
          state_d = PS_WAIT;
          wcnt_d  = irq_load;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_WAIT;
      wcnt_q  <= RST_LOAD;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign run         = (state_q == PS_RUN);
  assign idle        = (state_q == PS_IDLE);
  assign main_osc_en = !((state_q == PS_STOP) && cpu_low);
endmodule

// File: rtl/cpuclk_pwr_ctrl.sv
module cpuclk_pwr_ctrl
  import cpc_pkg::*;
#(
  parameter int DIV_FAST      = 4,
  parameter int DIV_MID       = 8,
  parameter int DIV_SLOW      = 64,
  parameter int SUB_DIV       = 4,
  parameter int RST_WAIT_LOG2 = 17,
  parameter int IRQ_WAIT_BASE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [2:0] wr_data,
  input  logic       irq,
  input  logic       sub_clk,
  output logic       cpu_clk,
  output logic       main_osc_en,
  output logic       sub_osc_en
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  clk_src_e   sel_req, sel_cur;
  logic       sub_stop;
  logic [1:0] wake_code;
  logic       cmd_idle, cmd_stop, sub_tick, run, pd_idle, cur_sub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_req   <= SRC_DIV64;
      sub_stop  <= 1'b0;
      wake_code <= 2'b00;
    end else if (wr_en) begin
      if (wr_addr == ADDR_MODE) begin
        sel_req  <= clk_src_e'(wr_data[1:0]);
        sub_stop <= wr_data[2];
      end
      if (wr_addr == ADDR_WAKE) wake_code <= wr_data[1:0];
    end
  end

  assign cmd_stop   = wr_en && (wr_addr == ADDR_CMD) && wr_data[1];
  assign cmd_idle   = wr_en && (wr_addr == ADDR_CMD) && wr_data[0] && !wr_data[1];
  assign cur_sub    = (sel_cur == SRC_SUB);
  assign sub_osc_en = !(sub_stop && (sel_req != SRC_SUB) && !cur_sub);

  cpc_edge_sync u_sub_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (sub_clk),
    .rise     (sub_tick)
  );

  cpc_pwr_fsm #(
    .RST_WAIT_LOG2 (RST_WAIT_LOG2),
    .IRQ_WAIT_BASE (IRQ_WAIT_BASE)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cmd_idle    (cmd_idle),
    .cmd_stop    (cmd_stop),
    .irq         (irq),
    .wake_code   (wake_code),
    .cpu_low     (!cpu_clk),
    .run         (run),
    .idle        (pd_idle),
    .main_osc_en (main_osc_en)
  );

  cpc_clk_gen #(
    .DIV_FAST (DIV_FAST),
    .DIV_MID  (DIV_MID),
    .DIV_SLOW (DIV_SLOW),
    .SUB_DIV  (SUB_DIV)
  ) u_gen (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .sel_req  (sel_req),
    .sub_tick (sub_tick),
    .cpu_clk  (cpu_clk),
    .sel_cur  (sel_cur)
  );
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker (
  input logic clk,
  input logic rst_n,
  input logic cpu_clk,
  input logic main_osc_en,
  input logic sub_osc_en,
  input logic irq,
  input logic run,
  input logic idle,
  input logic cur_sub
);
  // R4: a high phase spans at least two cycles
  p_min_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk) |-> $past(cpu_clk, 2));

  // R4: a low phase spans at least two cycles
  p_min_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk) |-> !$past(cpu_clk, 2));

  // R5, R8: a halted clock that is low stays low
  p_halt_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cpu_clk) |=> !cpu_clk);

  // R7: the oscillator is off only while the clock output is low
  p_osc_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !main_osc_en |-> !cpu_clk);

  // R6: an interrupt in idle resumes running on the next cycle
  p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && irq) |=> run);

  // R9: the subsystem oscillator stays on while it drives the clock
  p_sub_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cur_sub |-> sub_osc_en);
endmodule

bind cpuclk_pwr_ctrl cpc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cpu_clk     (cpu_clk),
  .main_osc_en (main_osc_en),
  .sub_osc_en  (sub_osc_en),
  .irq         (irq),
  .run         (run),
  .idle        (pd_idle),
  .cur_sub     (cur_sub)
);

// File: tb/cpuclk_pwr_ctrl_bench.sv
module cpuclk_pwr_ctrl_bench;
  localparam int RSTW = 8;
  localparam int IWB  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [2:0] wr_data = 3'd0;
  logic       irq = 1'b0;
  logic       sub_clk = 1'b0;
  logic       cpu_clk, main_osc_en, sub_osc_en;

  int checks = 0;
  int errors = 0;
  int glitches = 0;
  int run_len = 0;
  bit mon_on = 1'b0;
  bit mon_prev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always #80 sub_clk = ~sub_clk;

  cpuclk_pwr_ctrl #(
    .RST_WAIT_LOG2 (RSTW),
    .IRQ_WAIT_BASE (IWB)
  ) u_cpuclk_pwr_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .irq         (irq),
    .sub_clk     (sub_clk),
    .cpu_clk     (cpu_clk),
    .main_osc_en (main_osc_en),
    .sub_osc_en  (sub_osc_en)
  );

  // phase width monitor for R4
  always @(negedge clk) begin
    if (mon_on) begin
      if (cpu_clk != mon_prev) begin
        if (run_len < 2) glitches++;
        run_len = 1;
      end else begin
        run_len++;
      end
    end
    mon_prev = cpu_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [2:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // cycles until the next rising edge of cpu_clk, -1 on timeout
  task automatic next_rise(input int limit, output int n);
    bit prev;
    prev = cpu_clk;
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (!prev && cpu_clk) return;
      prev = cpu_clk;
      if (n > limit) begin n = -1; return; end
    end
  endtask

  task automatic period(output int p);
    int d;
    next_rise(400, d);
    next_rise(400, p);
  endtask

  task automatic stay_low(input int cycles, output bit ok);
    ok = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (cpu_clk) ok = 1'b0;
    end
  endtask

  task automatic t_reset();
    int n, p;
    @(negedge clk);
    check(main_osc_en && sub_osc_en && !cpu_clk, "R1 reset outputs",
          {main_osc_en, sub_osc_en, cpu_clk}, 3'b110);
    rst_n = 1'b1;
    mon_on = 1'b1;
    next_rise(600, n);
    check(n >= (1 << RSTW) && n <= (1 << RSTW) + 44, "R1 reset wait", n, 1 << RSTW);
    next_rise(400, p);
    check(p == 64, "R1 default period", p, 64);
  endtask

  task automatic t_div();
    int p;
    bus_wr(2'd0, 3'b001); period(p);
    check(p == 8, "R2 divide by 8", p, 8);
    bus_wr(2'd0, 3'b010); period(p);
    check(p == 4, "R2 divide by 4", p, 4);
    bus_wr(2'd0, 3'b000); period(p);
    check(p == 64, "R2 divide by 64", p, 64);
  endtask

  task automatic t_sub();
    int p;
    bus_wr(2'd0, 3'b011); period(p); period(p);
    check(p == 80, "R3 subsystem period", p, 80);
    bus_wr(2'd0, 3'b010); period(p);
    check(p == 4, "R4 switch back to divide by 4", p, 4);
  endtask

  task automatic t_sub_stop();
    int p;
    bus_wr(2'd0, 3'b110);
    check(sub_osc_en == 1'b0, "R9 sub stop on main source", sub_osc_en, 0);
    bus_wr(2'd0, 3'b111);
    check(sub_osc_en == 1'b1, "R9 sub stop ignored on sub source", sub_osc_en, 1);
    period(p); period(p);
    check(p == 80, "R9 sub clock still running", p, 80);
    bus_wr(2'd0, 3'b010); period(p);
  endtask

  task automatic t_idle();
    int n;
    bit ok;
    bus_wr(2'd2, 3'b001);
    repeat (6) @(negedge clk);
    stay_low(40, ok);
    check(ok && main_osc_en, "R5 idle holds clock, oscillator on",
          {ok, main_osc_en}, 2'b11);
    irq = 1'b1;
    next_rise(50, n);
    irq = 1'b0;
    check(n > 0 && n <= 6, "R6 idle wake latency", n, 3);
  endtask

  task automatic t_stop(input logic [2:0] cmd, input logic [1:0] code, input string req);
    int n, wl, p;
    bit ok;
    wl = 1 << (IWB + 2 * code);
    bus_wr(2'd1, {1'b0, code});
    bus_wr(2'd2, cmd);
    repeat (6) @(negedge clk);
    check(main_osc_en == 1'b0, req, main_osc_en, 0);
    stay_low(50, ok);
    check(ok && !main_osc_en, "R7 stop holds clock and oscillator off",
          {ok, main_osc_en}, 2'b10);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    @(negedge clk);
    check(main_osc_en == 1'b1, "R8 oscillator back on after irq", main_osc_en, 1);
    next_rise(2000, n);
    n = n + 2;
    check(n >= wl && n <= wl + 8, "R8 interrupt release wait", n, wl);
    period(p);
    check(p == 4, "R8 period after stop release", p, 4);
  endtask

  task automatic t_irq_run();
    int p;
    irq = 1'b1;
    period(p);
    check(p == 4, "R11 irq while running", p, 4);
    period(p);
    check(p == 4, "R11 irq while running, second period", p, 4);
    irq = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_div();
    t_sub();
    t_sub_stop();
    t_idle();
    t_stop(3'b010, 2'd1, "R7 stop drops oscillator");
    t_stop(3'b011, 2'd2, "R10 both bits select stop");
    t_irq_run();
    check(glitches == 0, "R4 no short phase seen", glitches, 0);
    finish_run();
  end
endmodule